// File: doc/BRIEF.md
# Dual-Port Writeback Slot Scheduler

This block is the writeback back end of a two-wide in-order pipeline. The pipeline has four result producers: two single-cycle arithmetic/logic units, a load/store unit and a multiplier. All four share a register file that has only two write ports. The producers have different latencies. Because of that, a write-port conflict is not visible when the instruction issues, only when its result arrives. The block therefore keeps a short table of how many writes are already booked for each of the next few clock edges. It refuses to issue an instruction whose booking would put a third write on one edge.

At writeback, each producer raises its own request with a destination and a value. The block steers the valid requests onto the two write ports by age. If two writes in the same cycle name the same register, the younger one wins. The register file has two write ports and four read ports. A read sees a value that is being written in the same cycle. This removes the need for a forwarding path from writeback.

Top module: `wb_slot_sched`

## Requirements
- R1: The issue unit codes are 0 = ALU, 1 = load/store, 2 = multiply; code 3 is treated as ALU. A granted instruction books one write on the clock edge that lies 1, 2 or 3 edges after the edge that grants it, for ALU, load/store and multiply respectively.
- R2: A valid slot-0 instruction is granted when fewer than two writes are already booked on its target edge; otherwise `iss_stall[0]` is raised in the same cycle.
- R3: A valid slot-1 instruction is granted only when slot 0 is not stalled and fewer than two writes are booked on its target edge, counting a slot-0 grant in the same cycle that targets the same edge; otherwise `iss_stall[1]` is raised. A stall on slot 1 never stalls slot 0.
- R4: `iss_stall[i]` is never high while `iss_vld[i]` is low.
- R5: A stalled instruction books nothing, and bookings move one edge closer on every clock.
- R6: Result request bits are multiply = bit 0, load/store = bit 1, ALU0 = bit 2, ALU1 = bit 3; a lower bit is the older result. With at most two requests in a cycle, every request with a non-zero destination is written at the next clock edge.
- R7: When two requests in one cycle name the same register, the register takes the value of the higher-numbered (younger) request.
- R8: Register 0 is never written and always reads as zero.
- R9: A read port whose address matches a write taking place in the same cycle returns the value being written.
- R10: After reset every register reads zero and no write is booked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| iss_vld | input | 2 | Instruction present in issue slot 0 / 1 (slot 0 is older) |
| iss_unit | input | 2x2 | Unit code per slot (0 ALU, 1 load/store, 2 multiply) |
| iss_stall | output | 2 | Slot must hold its instruction this cycle |
| res_vld | input | 4 | Write requests: bit0 multiply, bit1 load/store, bit2 ALU0, bit3 ALU1 |
| res_dst | input | 4xAW | Destination register per request |
| res_data | input | 4xDW | Result value per request |
| rd_addr | input | 4xAW | Read-port addresses |
| rd_data | output | 4xDW | Read-port data, combinational, with same-cycle bypass |

## Verification
A stall is a combinational answer in the cycle where the instruction is presented. The bench therefore drives each issue pattern after the falling edge and compares both stall bits 1 ns later, before the next rising edge. It then moves its own booking table forward at that edge. A write request becomes visible on the read ports in the same cycle through the bypass. It becomes visible from the stored state after exactly one rising edge. So every write pattern is checked twice: once through the bypass before the edge, and once by sweeping all registers through the four read ports after the edge, with requests removed.

// File: rtl/wbs_pkg.sv
package wbs_pkg;

    typedef enum logic [1:0] {
        UNIT_ALU = 2'd0,
        UNIT_LSU = 2'd1,
        UNIT_MUL = 2'd2
    } unit_e;

    localparam int N_SLOT   = 2;
    localparam int N_SRC    = 4;
    localparam int N_WP     = 2;
    localparam int N_RP     = 4;
    localparam int MAX_LAT  = 3;
    localparam int WR_LIMIT = 2;
    localparam int CW       = $clog2(WR_LIMIT + 1);

    typedef struct packed {
        logic       grant;
        logic [1:0] lat;
    } booking_t;

    function automatic logic [1:0] unit_lat(input logic [1:0] code);
        case (code)
            UNIT_LSU: return 2'd2;
            UNIT_MUL: return 2'd3;
            default:  return 2'd1;
        endcase
    endfunction

endpackage

// File: rtl/wbs_slot_tracker.sv
module wbs_slot_tracker
    import wbs_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst,
    input  logic [N_SLOT-1:0]          iss_vld,
    input  logic [N_SLOT-1:0][1:0]     iss_unit,
    output logic [N_SLOT-1:0]          iss_stall,
    output logic [CW-1:0]              booked_now
);

    logic [CW-1:0] book_q [MAX_LAT];
    logic [CW-1:0] book_d [MAX_LAT];
    logic [CW-1:0] ext    [MAX_LAT+1];
    booking_t      bk     [N_SLOT];

    always_comb begin
        for (int j = 0; j < MAX_LAT; j++) ext[j] = book_q[j];
        ext[MAX_LAT] = '0;

        bk[0].lat   = unit_lat(iss_unit[0]);
        bk[1].lat   = unit_lat(iss_unit[1]);
        bk[0].grant = iss_vld[0] && (int'(ext[bk[0].lat]) < WR_LIMIT);
        iss_stall[0] = iss_vld[0] && !bk[0].grant;
        bk[1].grant = iss_vld[1] && !iss_stall[0] &&
                      ((int'(ext[bk[1].lat]) +
                        ((bk[0].grant && bk[0].lat == bk[1].lat) ? 1 : 0)) < WR_LIMIT);
        iss_stall[1] = iss_vld[1] && !bk[1].grant;

        for (int j = 0; j < MAX_LAT; j++) begin
            int add;
            add = 0;
            for (int s = 0; s < N_SLOT; s++)
                if (bk[s].grant && int'(bk[s].lat) == j + 1) add++;
            book_d[j] = CW'(int'(ext[j+1]) + add);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int j = 0; j < MAX_LAT; j++) book_q[j] <= '0;
        end else begin
            for (int j = 0; j < MAX_LAT; j++) book_q[j] <= book_d[j];
        end
    end

    assign booked_now = book_q[0];

endmodule

// File: rtl/wbs_port_steer.sv
module wbs_port_steer
    import wbs_pkg::*;
#(
    parameter int AW = 4,
    parameter int DW = 16
) (
    input  logic [N_SRC-1:0]          req,
    input  logic [N_SRC-1:0][AW-1:0]  dst,
    input  logic [N_SRC-1:0][DW-1:0]  data,
    output logic [N_WP-1:0]           wp_en,
    output logic [N_WP-1:0][AW-1:0]   wp_addr,
    output logic [N_WP-1:0][DW-1:0]   wp_data
);

    localparam int SW = $clog2(N_SRC);

    logic [SW-1:0] sel_old, sel_new;
    logic          hit_old, hit_new;

    always_comb begin
        sel_old = '0;
        sel_new = '0;
        hit_old = 1'b0;
        hit_new = 1'b0;
        for (int i = 0; i < N_SRC; i++) begin
            if (req[i] && !hit_old) begin
                sel_old = SW'(i);
                hit_old = 1'b1;
            end else if (req[i] && !hit_new) begin
                sel_new = SW'(i);
                hit_new = 1'b1;
            end
        end

        wp_addr[0] = dst[sel_old];
        wp_data[0] = data[sel_old];
        wp_addr[1] = dst[sel_new];
        wp_data[1] = data[sel_new];
        wp_en[0]   = hit_old && (dst[sel_old] != '0) &&
                     !(hit_new && dst[sel_old] == dst[sel_new]);
        wp_en[1]   = hit_new && (dst[sel_new] != '0);
    end

endmodule

// File: rtl/wbs_regfile.sv
module wbs_regfile
    import wbs_pkg::*;
#(
    parameter int NREG = 16,
    parameter int DW   = 16,
    localparam int AW  = $clog2(NREG)
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [N_WP-1:0]           wp_en,
    input  logic [N_WP-1:0][AW-1:0]   wp_addr,
    input  logic [N_WP-1:0][DW-1:0]   wp_data,
    input  logic [N_RP-1:0][AW-1:0]   rd_addr,
    output logic [N_RP-1:0][DW-1:0]   rd_data
);

    logic [DW-1:0] mem [NREG];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < NREG; k++) mem[k] <= '0;
        end else begin
            for (int p = 0; p < N_WP; p++)
                if (wp_en[p]) mem[wp_addr[p]] <= wp_data[p];
        end
    end

    always_comb begin
        for (int r = 0; r < N_RP; r++) begin
            rd_data[r] = (rd_addr[r] == '0) ? '0 : mem[rd_addr[r]];
            for (int p = 0; p < N_WP; p++)
                if (wp_en[p] && wp_addr[p] == rd_addr[r]) rd_data[r] = wp_data[p];
        end
    end

endmodule

// File: rtl/wb_slot_sched.sv
module wb_slot_sched
    import wbs_pkg::*;
#(
    parameter int NREG = 16,
    parameter int DW   = 16,
    localparam int AW  = $clog2(NREG)
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [N_SLOT-1:0]          iss_vld,
    input  logic [N_SLOT-1:0][1:0]     iss_unit,
    output logic [N_SLOT-1:0]          iss_stall,
    input  logic [N_SRC-1:0]           res_vld,
    input  logic [N_SRC-1:0][AW-1:0]   res_dst,
    input  logic [N_SRC-1:0][DW-1:0]   res_data,
    input  logic [N_RP-1:0][AW-1:0]    rd_addr,
    output logic [N_RP-1:0][DW-1:0]    rd_data
);

    logic [N_WP-1:0]         wp_en;
    logic [N_WP-1:0][AW-1:0] wp_addr;
    logic [N_WP-1:0][DW-1:0] wp_data;
    logic [CW-1:0]           booked_now;

    wbs_slot_tracker u_tracker (
        .clk        (clk),
        .rst        (rst),
        .iss_vld    (iss_vld),
        .iss_unit   (iss_unit),
        .iss_stall  (iss_stall),
        .booked_now (booked_now)
    );

    wbs_port_steer #(.AW(AW), .DW(DW)) u_steer (
        .req     (res_vld),
        .dst     (res_dst),
        .data    (res_data),
        .wp_en   (wp_en),
        .wp_addr (wp_addr),
        .wp_data (wp_data)
    );

    wbs_regfile #(.NREG(NREG), .DW(DW)) u_rf (
        .clk     (clk),
        .rst     (rst),
        .wp_en   (wp_en),
        .wp_addr (wp_addr),
        .wp_data (wp_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

endmodule

// File: rtl/wb_slot_sched_chk.sv
module wb_slot_sched_chk
    import wbs_pkg::*;
#(
    parameter int AW = 4
) (
    input logic                     clk,
    input logic                     rst,
    input logic [N_SLOT-1:0]        iss_vld,
    input logic [N_SLOT-1:0]        iss_stall,
    input logic [N_SRC-1:0]         res_vld,
    input logic [N_WP-1:0]          wp_en,
    input logic [N_WP-1:0][AW-1:0]  wp_addr,
    input logic [CW-1:0]            booked_now
);

    assert_stall_needs_valid_R4: assert property (@(posedge clk) disable iff (rst)
        (iss_stall & ~iss_vld) == '0);

    assert_in_order_stall_R3: assert property (@(posedge clk) disable iff (rst)
        (iss_stall[0] && iss_vld[1]) |-> iss_stall[1]);

    assert_booking_bound_R2: assert property (@(posedge clk) disable iff (rst)
        int'(booked_now) <= WR_LIMIT);

    assert_two_requests_R6: assert property (@(posedge clk) disable iff (rst)
        $countones(res_vld) <= WR_LIMIT);

    assert_no_zero_write_p0_R8: assert property (@(posedge clk) disable iff (rst)
        wp_en[0] |-> wp_addr[0] != '0);

    assert_no_zero_write_p1_R8: assert property (@(posedge clk) disable iff (rst)
        wp_en[1] |-> wp_addr[1] != '0);

    assert_distinct_ports_R7: assert property (@(posedge clk) disable iff (rst)
        (&wp_en) |-> wp_addr[0] != wp_addr[1]);

endmodule

bind wb_slot_sched wb_slot_sched_chk #(.AW(AW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .iss_vld    (iss_vld),
    .iss_stall  (iss_stall),
    .res_vld    (res_vld),
    .wp_en      (wp_en),
    .wp_addr    (wp_addr),
    .booked_now (booked_now)
);

// File: tb/wb_slot_sched_bench.sv
`timescale 1ns/1ps
module wb_slot_sched_bench;

    localparam int NREG = 16;
    localparam int DW   = 16;
    localparam int AW   = 4;

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic [1:0]          iss_vld = '0;
    logic [1:0][1:0]     iss_unit = '0;
    logic [1:0]          iss_stall;
    logic [3:0]          res_vld = '0;
    logic [3:0][AW-1:0]  res_dst = '0;
    logic [3:0][DW-1:0]  res_data = '0;
    logic [3:0][AW-1:0]  rd_addr = '0;
    logic [3:0][DW-1:0]  rd_data;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    logic [DW-1:0] exp_rf [NREG];

    always #2.5 clk = ~clk;

    wb_slot_sched #(.NREG(NREG), .DW(DW)) u_wb_slot_sched (
        .clk(clk), .rst(rst), .iss_vld(iss_vld), .iss_unit(iss_unit),
        .iss_stall(iss_stall), .res_vld(res_vld), .res_dst(res_dst),
        .res_data(res_data), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic sweep_regs(input string tag);
        for (int g = 0; g < NREG / 4; g++) begin
            for (int i = 0; i < 4; i++) rd_addr[i] = AW'(g * 4 + i);
            #0.5;
            for (int i = 0; i < 4; i++)
                check(tag, int'(rd_data[i]), int'(exp_rf[g * 4 + i]));
        end
    endtask

    function automatic int lat_of(input int code);
        return (code == 1) ? 2 : (code == 2) ? 3 : 1;
    endfunction

    initial begin
        int m [4];
        int seed;
        for (int k = 0; k < NREG; k++) exp_rf[k] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R10: registers cleared, nothing booked
        sweep_regs("R10 reset regs");
        @(negedge clk);
        iss_vld = 2'b11; iss_unit[0] = 2'd2; iss_unit[1] = 2'd2;
        #1;
        check("R10 R3 empty table grants two multiplies", int'(iss_stall), 0);
        @(negedge clk);
        iss_vld = 2'b01; iss_unit[0] = 2'd1;
        #1;
        check("R1 R2 load collides with booked multiplies", int'(iss_stall), 1);
        @(negedge clk);
        iss_vld = '0;
        repeat (4) @(negedge clk);

        // tracker sweep with a software booking table
        for (int k = 0; k < 4; k++) m[k] = 0;
        seed = 7;
        for (int n = 0; n < 900; n++) begin
            int v0, v1, u0, u1, l0, l1, g0, g1, s0, s1;
            seed = seed * 1103515245 + 12345;
            v0 = (seed >>> 16) & 1;
            v1 = (seed >>> 17) & 1;
            u0 = ((seed >>> 18) & 255) % 4;
            u1 = ((seed >>> 26) & 31) % 4;
            if ((n % 5) == 0) begin v0 = 1; v1 = 1; end
            iss_vld = {1'(v1), 1'(v0)};
            iss_unit[0] = 2'(u0);
            iss_unit[1] = 2'(u1);
            l0 = lat_of(u0);
            l1 = lat_of(u1);
            g0 = (v0 == 1 && m[l0] < 2) ? 1 : 0;
            s0 = (v0 == 1 && g0 == 0) ? 1 : 0;
            g1 = (v1 == 1 && s0 == 0 &&
                  (m[l1] + ((g0 == 1 && l0 == l1) ? 1 : 0)) < 2) ? 1 : 0;
            s1 = (v1 == 1 && g1 == 0) ? 1 : 0;
            #1;
            check("R1 R2 R5 slot0 stall", int'(iss_stall[0]), s0);
            check("R3 R4 slot1 stall", int'(iss_stall[1]), s1);
            if (g0 == 1) m[l0]++;
            if (g1 == 1) m[l1]++;
            m[0] = m[1]; m[1] = m[2]; m[2] = m[3]; m[3] = 0;
            @(negedge clk);
        end
        iss_vld = '0;
        @(negedge clk);

        // write steering sweep: round 0 distinct, 1 shared dest, 2 zero dest
        for (int r = 0; r < 3; r++) begin
            for (int p = 0; p < 16; p++) begin
                string tag;
                if ($countones(4'(p)) > 2) continue;
                tag = (r == 0) ? "R6 R9" : (r == 1) ? "R7 R9" : "R8 R9";
                for (int i = 0; i < 4; i++) begin
                    int d;
                    if (r == 0)      d = ((p * 3 + i * 4 + r) % 15) + 1;
                    else if (r == 1) d = (p % 15) + 1;
                    else             d = ((i % 2) == 0) ? 0 : (p + i) % 16;
                    res_dst[i]  = AW'(d);
                    res_data[i] = DW'(p * 97 + i * 13 + r * 1000 + 1);
                    rd_addr[i]  = AW'(d);
                end
                res_vld = 4'(p);
                for (int i = 0; i < 4; i++)
                    if (res_vld[i] && res_dst[i] != '0) exp_rf[res_dst[i]] = res_data[i];
                #1;
                for (int i = 0; i < 4; i++)
                    check({tag, " bypass"}, int'(rd_data[i]), int'(exp_rf[res_dst[i]]));
                @(posedge clk);
                #1;
                res_vld = '0;
                sweep_regs({tag, " stored"});
                @(negedge clk);
            end
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog R10 actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule